// File: doc/BRIEF.md
# Hardware Breakpoint Unit

This block sits beside a small 4-bit CPU core and watches its activity to decide when execution has to stop for a debugger. It evaluates five independent break sources each cycle. The first is a match of the fetch address against a small table of programmed addresses. The second is an ordered three-address sequence with a pass count on its final step. The third is a data-memory access qualified by address range, masked data and masked direction. The fourth is a masked comparison of the register and flag snapshot taken when an instruction retires. The fifth is the falling edge of an external active-low break pin.

Any source that is satisfied raises a one-cycle break request and records which sources fired in a cause register. The stall logic that consumes the request and the host-side programming path are not part of the block: the comparison values arrive on static configuration ports. While the CPU acknowledges an interrupt, break requests are held back. They are issued once the acknowledge ends, so the stopped CPU sits at the handler entry address.

Top module: `brk_unit`

## Requirements
- R1: A fetch strobe whose address equals any enabled entry of the address table raises brkReq for exactly one cycle after the next clock edge, which is ahead of that instruction's execution. brkCause bit 0 is set.
- R2: The sequence break advances only on address 1, then address 2, then address 3. Fetches of other addresses, or of a later step's address out of turn, leave the progress where it is.
- R3: Once the sequence reaches its last step, address 3 must be fetched seqCount times before brkReq rises with brkCause bit 1. A seqCount of zero behaves as one, and the sequence starts over from address 1 after it fires.
- R4: A rising edge of run (an emulation restart) clears the sequence progress, its pass counter and any pending break.
- R5: A memory access fires brkReq with brkCause bit 2 when all three conditions hold. The address must lie between dataLo and dataHi inclusive. The data must equal dataVal on every bit set in dataMask. The direction memWr must equal rwVal when rwMask is 1.
- R6: An instrDone strobe fires brkReq with brkCause bit 3 when A, B, X, Y and the flags all equal their programmed values on the bits set in each one's mask. The flag vector is ordered E (bit 3), I (bit 2), C (bit 1), Z (bit 0).
- R7: A high-to-low transition of extBrkN while run is high fires brkReq with brkCause bit 4. A level held low does not fire again, and a transition while run is low is ignored.
- R8: The sources are ORed. When several fire in the same cycle, a single brkReq is raised and brkCause holds a 1 for each of them.
- R9: Sources that fire while intAck is high are held, and brkReq stays low. The held break is issued at the first clock edge at which intAck is low, and brkCause carries the held sources.
- R10: After reset, brkReq and brkCause are 0. While run is low, no source can raise a break.
- R11: brkCause keeps its value after brkReq drops, until the next break or a restart clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Target running; rising edge marks an emulation restart |
| fetchValid | input | 1 | Fetch address strobe |
| fetchPc | input | PC_W | Address of the instruction being fetched |
| memValid | input | 1 | Data-memory access strobe |
| memAddr | input | DADDR_W | Data access address |
| memData | input | DATA_W | Data read or written |
| memWr | input | 1 | 1 = write, 0 = read |
| instrDone | input | 1 | Instruction retired; register snapshot valid |
| regA | input | DATA_W | A register snapshot |
| regB | input | DATA_W | B register snapshot |
| regX | input | XY_W | X register snapshot |
| regY | input | XY_W | Y register snapshot |
| regFlags | input | 4 | Flags E,I,C,Z (bits 3..0) |
| intAck | input | 1 | Interrupt acknowledge and stacking in progress |
| extBrkN | input | 1 | External break pin, active low |
| pcBrkEn | input | NUM_PC | Enable for each address-table entry |
| pcBrkAddr | input | NUM_PC*PC_W | Address table, entry i at bits i*PC_W upward |
| seqEn | input | 1 | Sequence break enable |
| seqAddr1 | input | PC_W | First sequence address |
| seqAddr2 | input | PC_W | Second sequence address |
| seqAddr3 | input | PC_W | Final sequence address |
| seqCount | input | CNT_W | Required hits of the final address |
| dataEn | input | 1 | Data-access break enable |
| dataLo | input | DADDR_W | Lowest address of the range |
| dataHi | input | DADDR_W | Highest address of the range |
| dataVal | input | DATA_W | Data compare value |
| dataMask | input | DATA_W | Data compare mask, 1 = compare |
| rwVal | input | 1 | Direction compare value |
| rwMask | input | 1 | Direction compare mask |
| regEn | input | 1 | Register break enable |
| regAVal | input | DATA_W | A compare value |
| regAMask | input | DATA_W | A compare mask |
| regBVal | input | DATA_W | B compare value |
| regBMask | input | DATA_W | B compare mask |
| regXVal | input | XY_W | X compare value |
| regXMask | input | XY_W | X compare mask |
| regYVal | input | XY_W | Y compare value |
| regYMask | input | XY_W | Y compare mask |
| flagVal | input | 4 | Flag compare value |
| flagMask | input | 4 | Flag compare mask |
| brkReq | output | 1 | One-cycle break request |
| brkCause | output | 5 | Sources of the last break: 0 address, 1 sequence, 2 data, 3 register, 4 pin |

## Verification
Every source is decided combinationally from the strobes of the current cycle and passes through one register. A stimulus applied during a cycle therefore shows up on brkReq and brkCause just after the following rising edge. The pin edge is compared against the registered previous pin level, so it follows the same one-edge timing. The bench drives inputs a nanosecond after an edge, advances exactly one edge, and samples there. It then advances further edges to confirm that brkReq fell, or that no late request appears. For held breaks it counts one edge after intAck is released.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int CAUSE_W = 5;
  localparam int C_PC    = 0;
  localparam int C_SEQ   = 1;
  localparam int C_DATA  = 2;
  localparam int C_REG   = 3;
  localparam int C_EXT   = 4;

  // Comparator strobes passed from the datapath to the control
  typedef struct packed {
    logic pcHit;
    logic seqA1;
    logic seqA2;
    logic seqA3;
    logic dataHit;
    logic regHit;
  } brk_match_t;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int NUM_PC  = 4,
  parameter int DADDR_W = 12,
  parameter int DATA_W  = 4,
  parameter int XY_W    = 8
) (
  input  logic                   fetchValid,
  input  logic [PC_W-1:0]        fetchPc,
  input  logic [NUM_PC-1:0]      pcBrkEn,
  input  logic [NUM_PC*PC_W-1:0] pcBrkAddr,
  input  logic [PC_W-1:0]        seqAddr1,
  input  logic [PC_W-1:0]        seqAddr2,
  input  logic [PC_W-1:0]        seqAddr3,
  input  logic                   memValid,
  input  logic [DADDR_W-1:0]     memAddr,
  input  logic [DATA_W-1:0]      memData,
  input  logic                   memWr,
  input  logic                   dataEn,
  input  logic [DADDR_W-1:0]     dataLo,
  input  logic [DADDR_W-1:0]     dataHi,
  input  logic [DATA_W-1:0]      dataVal,
  input  logic [DATA_W-1:0]      dataMask,
  input  logic                   rwVal,
  input  logic                   rwMask,
  input  logic                   instrDone,
  input  logic [DATA_W-1:0]      regA,
  input  logic [DATA_W-1:0]      regB,
  input  logic [XY_W-1:0]        regX,
  input  logic [XY_W-1:0]        regY,
  input  logic [3:0]             regFlags,
  input  logic                   regEn,
  input  logic [DATA_W-1:0]      regAVal,
  input  logic [DATA_W-1:0]      regAMask,
  input  logic [DATA_W-1:0]      regBVal,
  input  logic [DATA_W-1:0]      regBMask,
  input  logic [XY_W-1:0]        regXVal,
  input  logic [XY_W-1:0]        regXMask,
  input  logic [XY_W-1:0]        regYVal,
  input  logic [XY_W-1:0]        regYMask,
  input  logic [3:0]             flagVal,
  input  logic [3:0]             flagMask,
  output brk_match_t             match
);

  // One comparator per address-table entry
  logic [NUM_PC-1:0] entryHit;

  for (genvar i = 0; i < NUM_PC; i++) begin : g_pcCmp
    assign entryHit[i] = pcBrkEn[i] && (fetchPc == pcBrkAddr[i*PC_W +: PC_W]);
  end

  logic inRange, dataOk, dirOk;
  logic aOk, bOk, xOk, yOk, fOk;

  always_comb begin
    inRange = (memAddr >= dataLo) && (memAddr <= dataHi);
    dataOk  = ((memData ^ dataVal) & dataMask) == '0;
    dirOk   = !(rwMask && (memWr != rwVal));

    aOk = ((regA ^ regAVal) & regAMask) == '0;
    bOk = ((regB ^ regBVal) & regBMask) == '0;
    xOk = ((regX ^ regXVal) & regXMask) == '0;
    yOk = ((regY ^ regYVal) & regYMask) == '0;
    fOk = ((regFlags ^ flagVal) & flagMask) == '0;

    match.pcHit   = fetchValid && (|entryHit);
    match.seqA1   = fetchValid && (fetchPc == seqAddr1);
    match.seqA2   = fetchValid && (fetchPc == seqAddr2);
    match.seqA3   = fetchValid && (fetchPc == seqAddr3);
    match.dataHit = dataEn && memValid && inRange && dataOk && dirOk;
    match.regHit  = regEn && instrDone && aOk && bOk && xOk && yOk && fOk;
  end

endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               extBrkN,
  input  logic               intAck,
  input  logic               seqEn,
  input  logic [CNT_W-1:0]   seqCount,
  input  brk_match_t         match,
  output logic               brkReq,
  output logic [CAUSE_W-1:0] brkCause
);

  localparam logic [1:0] SEQ_IDLE = 2'd0;
  localparam logic [1:0] SEQ_GOT1 = 2'd1;
  localparam logic [1:0] SEQ_GOT2 = 2'd2;

  logic               runPrev;
  logic               extPrev;
  logic               pastValid;
  logic               restart;
  logic               extFall;
  logic [1:0]         seqStage;
  logic [CNT_W-1:0]   seqCnt;
  logic [CNT_W-1:0]   lastIdx;
  logic               seqFire;
  logic [CAUSE_W-1:0] hits;
  logic [CAUSE_W-1:0] pend;
  logic [CAUSE_W-1:0] combined;

  always_comb begin
    restart  = run && !runPrev;
    extFall  = extPrev && !extBrkN;
    lastIdx  = (seqCount == '0) ? '0 : seqCount - CNT_W'(1);
    seqFire  = run && seqEn && (seqStage == SEQ_GOT2) && match.seqA3 && (seqCnt == lastIdx);
    hits[C_PC]   = run && match.pcHit;
    hits[C_SEQ]  = seqFire;
    hits[C_DATA] = run && match.dataHit;
    hits[C_REG]  = run && match.regHit;
    hits[C_EXT]  = run && extFall;
    combined = pend | hits;
  end

  // Edge detectors for restart and the external pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runPrev   <= 1'b0;
      extPrev   <= 1'b1;
      pastValid <= 1'b0;
    end else begin
      runPrev   <= run;
      extPrev   <= extBrkN;
      pastValid <= 1'b1;
    end
  end

  // Ordered three-step sequencer with pass counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqStage <= SEQ_IDLE;
      seqCnt   <= '0;
    end else if (restart || !seqEn) begin
      seqStage <= SEQ_IDLE;
      seqCnt   <= '0;
    end else if (run) begin
      case (seqStage)
        SEQ_IDLE: if (match.seqA1) seqStage <= SEQ_GOT1;
        SEQ_GOT1: if (match.seqA2) seqStage <= SEQ_GOT2;
        SEQ_GOT2: begin
          if (seqFire) begin
            seqStage <= SEQ_IDLE;
            seqCnt   <= '0;
          end else if (match.seqA3) begin
            seqCnt <= seqCnt + CNT_W'(1);
          end
        end
        default: seqStage <= SEQ_IDLE;
      endcase
    end
  end

  // Request issue, interrupt hold-off and cause capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      brkReq   <= 1'b0;
      brkCause <= '0;
    end else if (restart) begin
      pend     <= '0;
      brkReq   <= 1'b0;
      brkCause <= '0;
    end else if (intAck) begin
      pend   <= combined;
      brkReq <= 1'b0;
    end else begin
      pend   <= '0;
      brkReq <= |combined;
      if (|combined) brkCause <= combined;
    end
  end

  // R9
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    brkReq |-> !$past(intAck));

  // R8
  cause_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brkReq |-> (brkCause != '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    (seqStage != $past(seqStage)) |-> (seqStage == SEQ_IDLE || seqStage == $past(seqStage) + 2'd1));

  // R3
  seq_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seqFire |=> (seqStage == SEQ_IDLE && seqCnt == '0));

  // R3
  cnt_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seqCnt != '0) |-> (seqStage == SEQ_GOT2));

  // R4
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    $past(restart) |-> (!brkReq && brkCause == '0 && seqStage == SEQ_IDLE));

endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int NUM_PC  = 4,
  parameter int DADDR_W = 12,
  parameter int DATA_W  = 4,
  parameter int XY_W    = 8,
  parameter int CNT_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   fetchValid,
  input  logic [PC_W-1:0]        fetchPc,
  input  logic                   memValid,
  input  logic [DADDR_W-1:0]     memAddr,
  input  logic [DATA_W-1:0]      memData,
  input  logic                   memWr,
  input  logic                   instrDone,
  input  logic [DATA_W-1:0]      regA,
  input  logic [DATA_W-1:0]      regB,
  input  logic [XY_W-1:0]        regX,
  input  logic [XY_W-1:0]        regY,
  input  logic [3:0]             regFlags,
  input  logic                   intAck,
  input  logic                   extBrkN,
  input  logic [NUM_PC-1:0]      pcBrkEn,
  input  logic [NUM_PC*PC_W-1:0] pcBrkAddr,
  input  logic                   seqEn,
  input  logic [PC_W-1:0]        seqAddr1,
  input  logic [PC_W-1:0]        seqAddr2,
  input  logic [PC_W-1:0]        seqAddr3,
  input  logic [CNT_W-1:0]       seqCount,
  input  logic                   dataEn,
  input  logic [DADDR_W-1:0]     dataLo,
  input  logic [DADDR_W-1:0]     dataHi,
  input  logic [DATA_W-1:0]      dataVal,
  input  logic [DATA_W-1:0]      dataMask,
  input  logic                   rwVal,
  input  logic                   rwMask,
  input  logic                   regEn,
  input  logic [DATA_W-1:0]      regAVal,
  input  logic [DATA_W-1:0]      regAMask,
  input  logic [DATA_W-1:0]      regBVal,
  input  logic [DATA_W-1:0]      regBMask,
  input  logic [XY_W-1:0]        regXVal,
  input  logic [XY_W-1:0]        regXMask,
  input  logic [XY_W-1:0]        regYVal,
  input  logic [XY_W-1:0]        regYMask,
  input  logic [3:0]             flagVal,
  input  logic [3:0]             flagMask,
  output logic                   brkReq,
  output logic [CAUSE_W-1:0]     brkCause
);

  brk_match_t matchStb;

  brk_datapath #(
    .PC_W(PC_W), .NUM_PC(NUM_PC), .DADDR_W(DADDR_W), .DATA_W(DATA_W), .XY_W(XY_W)
  ) u_datapath (
    .fetchValid(fetchValid), .fetchPc(fetchPc),
    .pcBrkEn(pcBrkEn), .pcBrkAddr(pcBrkAddr),
    .seqAddr1(seqAddr1), .seqAddr2(seqAddr2), .seqAddr3(seqAddr3),
    .memValid(memValid), .memAddr(memAddr), .memData(memData), .memWr(memWr),
    .dataEn(dataEn), .dataLo(dataLo), .dataHi(dataHi),
    .dataVal(dataVal), .dataMask(dataMask), .rwVal(rwVal), .rwMask(rwMask),
    .instrDone(instrDone), .regA(regA), .regB(regB), .regX(regX), .regY(regY),
    .regFlags(regFlags), .regEn(regEn),
    .regAVal(regAVal), .regAMask(regAMask), .regBVal(regBVal), .regBMask(regBMask),
    .regXVal(regXVal), .regXMask(regXMask), .regYVal(regYVal), .regYMask(regYMask),
    .flagVal(flagVal), .flagMask(flagMask),
    .match(matchStb)
  );

  brk_control #(
    .CNT_W(CNT_W)
  ) u_control (
    .clk(clk), .rst_n(rst_n), .run(run), .extBrkN(extBrkN), .intAck(intAck),
    .seqEn(seqEn), .seqCount(seqCount), .match(matchStb),
    .brkReq(brkReq), .brkCause(brkCause)
  );

endmodule

// File: tb/brk_unit_tb.sv
module brk_unit_tb;
  localparam int PC_W = 16, NUM_PC = 4, DADDR_W = 12, DATA_W = 4, XY_W = 8, CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic fetchValid = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic memValid = 1'b0;
  logic [DADDR_W-1:0] memAddr = '0;
  logic [DATA_W-1:0] memData = '0;
  logic memWr = 1'b0;
  logic instrDone = 1'b0;
  logic [DATA_W-1:0] regA = '0, regB = '0;
  logic [XY_W-1:0] regX = '0, regY = '0;
  logic [3:0] regFlags = '0;
  logic intAck = 1'b0;
  logic extBrkN = 1'b1;
  logic [NUM_PC-1:0] pcBrkEn = '0;
  logic [NUM_PC*PC_W-1:0] pcBrkAddr = '0;
  logic seqEn = 1'b0;
  logic [PC_W-1:0] seqAddr1 = '0, seqAddr2 = '0, seqAddr3 = '0;
  logic [CNT_W-1:0] seqCount = '0;
  logic dataEn = 1'b0;
  logic [DADDR_W-1:0] dataLo = '0, dataHi = '0;
  logic [DATA_W-1:0] dataVal = '0, dataMask = '0;
  logic rwVal = 1'b0, rwMask = 1'b0;
  logic regEn = 1'b0;
  logic [DATA_W-1:0] regAVal = '0, regAMask = '0, regBVal = '0, regBMask = '0;
  logic [XY_W-1:0] regXVal = '0, regXMask = '0, regYVal = '0, regYMask = '0;
  logic [3:0] flagVal = '0, flagMask = '0;
  logic brkReq;
  logic [4:0] brkCause;

  int totalCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  brk_unit #(
    .PC_W(PC_W), .NUM_PC(NUM_PC), .DADDR_W(DADDR_W), .DATA_W(DATA_W), .XY_W(XY_W), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .memValid(memValid), .memAddr(memAddr), .memData(memData), .memWr(memWr),
    .instrDone(instrDone), .regA(regA), .regB(regB), .regX(regX), .regY(regY),
    .regFlags(regFlags), .intAck(intAck), .extBrkN(extBrkN),
    .pcBrkEn(pcBrkEn), .pcBrkAddr(pcBrkAddr), .seqEn(seqEn),
    .seqAddr1(seqAddr1), .seqAddr2(seqAddr2), .seqAddr3(seqAddr3), .seqCount(seqCount),
    .dataEn(dataEn), .dataLo(dataLo), .dataHi(dataHi), .dataVal(dataVal), .dataMask(dataMask),
    .rwVal(rwVal), .rwMask(rwMask), .regEn(regEn),
    .regAVal(regAVal), .regAMask(regAMask), .regBVal(regBVal), .regBMask(regBMask),
    .regXVal(regXVal), .regXMask(regXMask), .regYVal(regYVal), .regYMask(regYMask),
    .flagVal(flagVal), .flagMask(flagMask),
    .brkReq(brkReq), .brkCause(brkCause)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic disableAll();
    pcBrkEn = '0; seqEn = 1'b0; dataEn = 1'b0; regEn = 1'b0;
    fetchValid = 1'b0; memValid = 1'b0; instrDone = 1'b0; intAck = 1'b0; extBrkN = 1'b1;
    step(); step();
  endtask

  task automatic fetch(input logic [PC_W-1:0] pc);
    fetchValid = 1'b1; fetchPc = pc;
    step();
    fetchValid = 1'b0;
  endtask

  task automatic restartRun();
    run = 1'b0; step();
    run = 1'b1; step();
  endtask

  task automatic testReset();
    chk("R10 reset brkReq", 32'(brkReq), 0);
    chk("R10 reset brkCause", 32'(brkCause), 0);
  endtask

  task automatic testPc();
    disableAll();
    pcBrkAddr = {16'h0000, 16'h0000, 16'h0345, 16'h0123};
    pcBrkEn = 4'b0011;
    fetch(16'h0345);
    chk("R1 entry1 req", 32'(brkReq), 1);
    chk("R1 entry1 cause", 32'(brkCause), 32'h01);
    step();
    chk("R1 single cycle", 32'(brkReq), 0);
    chk("R11 cause held", 32'(brkCause), 32'h01);
    fetch(16'h0124);
    chk("R1 no match", 32'(brkReq), 0);
    fetch(16'h0123);
    chk("R1 entry0 req", 32'(brkReq), 1);
  endtask

  task automatic testRunGate();
    disableAll();
    pcBrkEn = 4'b0001;
    run = 1'b0; step();
    fetch(16'h0123);
    chk("R10 run low blocks", 32'(brkReq), 0);
    restartRun();
    chk("R11 restart clears cause", 32'(brkCause), 0);
    step();
  endtask

  task automatic testSeqOrder();
    disableAll();
    seqAddr1 = 16'h0100; seqAddr2 = 16'h0200; seqAddr3 = 16'h0300; seqCount = 16'd3;
    seqEn = 1'b1;
    fetch(16'h0200); chk("R2 a2 first", 32'(brkReq), 0);
    fetch(16'h0300); chk("R2 a3 first", 32'(brkReq), 0);
    fetch(16'h0100); chk("R2 a1", 32'(brkReq), 0);
    fetch(16'h0300); chk("R2 a3 out of turn", 32'(brkReq), 0);
    fetch(16'h0200); chk("R2 a2", 32'(brkReq), 0);
    fetch(16'h0300); chk("R3 pass 1", 32'(brkReq), 0);
    fetch(16'h0300); chk("R3 pass 2", 32'(brkReq), 0);
    fetch(16'h0300);
    chk("R3 pass 3 fires", 32'(brkReq), 1);
    chk("R3 cause", 32'(brkCause), 32'h02);
    fetch(16'h0300); chk("R3 starts over", 32'(brkReq), 0);
  endtask

  task automatic testSeqZero();
    disableAll();
    seqCount = '0; seqEn = 1'b1;
    fetch(16'h0100); fetch(16'h0200);
    fetch(16'h0300);
    chk("R3 zero as one", 32'(brkReq), 1);
  endtask

  task automatic testSeqRestart();
    disableAll();
    seqCount = 16'd1; seqEn = 1'b1;
    fetch(16'h0100); fetch(16'h0200);
    restartRun(); step();
    fetch(16'h0300);
    chk("R4 restart clears sequence", 32'(brkReq), 0);
    fetch(16'h0100); fetch(16'h0200); fetch(16'h0300);
    chk("R4 sequence after restart", 32'(brkReq), 1);
  endtask

  task automatic mem(input logic [DADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic w);
    memValid = 1'b1; memAddr = a; memData = d; memWr = w;
    step();
    memValid = 1'b0;
  endtask

  task automatic testData();
    disableAll();
    dataLo = 12'h020; dataHi = 12'h02F; dataVal = 4'hA; dataMask = 4'hE;
    rwVal = 1'b1; rwMask = 1'b1; dataEn = 1'b1;
    mem(12'h020, 4'hB, 1'b1);
    chk("R5 low bound masked bit", 32'(brkReq), 1);
    chk("R5 cause", 32'(brkCause), 32'h04);
    mem(12'h02F, 4'hA, 1'b1); chk("R5 high bound", 32'(brkReq), 1);
    mem(12'h030, 4'hA, 1'b1); chk("R5 above range", 32'(brkReq), 0);
    mem(12'h01F, 4'hA, 1'b1); chk("R5 below range", 32'(brkReq), 0);
    mem(12'h025, 4'h2, 1'b1); chk("R5 data mismatch", 32'(brkReq), 0);
    mem(12'h025, 4'hA, 1'b0); chk("R5 direction mismatch", 32'(brkReq), 0);
    rwMask = 1'b0;
    mem(12'h025, 4'hA, 1'b0); chk("R5 direction masked", 32'(brkReq), 1);
  endtask

  task automatic retire(input logic [3:0] a, input logic [3:0] f, input logic done);
    regA = a; regFlags = f; regB = 4'h7; regX = 8'h5A; regY = 8'hC3; instrDone = done;
    step();
    instrDone = 1'b0;
  endtask

  task automatic testReg();
    disableAll();
    regAVal = 4'h5; regAMask = 4'hF; flagVal = 4'b0100; flagMask = 4'b0100;
    regBMask = '0; regXMask = '0; regYMask = '0; regEn = 1'b1;
    retire(4'h5, 4'b0100, 1'b1);
    chk("R6 match", 32'(brkReq), 1);
    chk("R6 cause", 32'(brkCause), 32'h08);
    retire(4'h5, 4'b0000, 1'b1); chk("R6 flag I mismatch", 32'(brkReq), 0);
    retire(4'h5, 4'b0100, 1'b0); chk("R6 no retire", 32'(brkReq), 0);
    retire(4'h5, 4'b1111, 1'b1); chk("R6 other flags masked", 32'(brkReq), 1);
    regXVal = 8'h5B; regXMask = 8'h01;
    retire(4'h5, 4'b0100, 1'b1); chk("R6 X mismatch", 32'(brkReq), 0);
    regXMask = '0;
  endtask

  task automatic testExt();
    disableAll();
    extBrkN = 1'b0; step();
    chk("R7 falling edge", 32'(brkReq), 1);
    chk("R7 cause", 32'(brkCause), 32'h10);
    step(); chk("R7 low level no repeat", 32'(brkReq), 0);
    extBrkN = 1'b1; step(); chk("R7 rising ignored", 32'(brkReq), 0);
    run = 1'b0; step();
    extBrkN = 1'b0; step();
    chk("R7 not running", 32'(brkReq), 0);
    extBrkN = 1'b1; step();
    run = 1'b1; step(); step();
  endtask

  task automatic testOr();
    disableAll();
    pcBrkEn = 4'b0001; dataEn = 1'b1; rwMask = 1'b0;
    fetchValid = 1'b1; fetchPc = 16'h0123;
    memValid = 1'b1; memAddr = 12'h022; memData = 4'hA;
    step();
    fetchValid = 1'b0; memValid = 1'b0;
    chk("R8 combined req", 32'(brkReq), 1);
    chk("R8 both causes", 32'(brkCause), 32'h05);
    step(); chk("R8 single request", 32'(brkReq), 0);
  endtask

  task automatic testHold();
    disableAll();
    pcBrkEn = 4'b0001;
    intAck = 1'b1;
    fetch(16'h0123);
    chk("R9 held during ack", 32'(brkReq), 0);
    step();
    chk("R9 still held", 32'(brkReq), 0);
    intAck = 1'b0;
    step();
    chk("R9 issued after ack", 32'(brkReq), 1);
    chk("R9 held cause", 32'(brkCause), 32'h01);
    step(); chk("R9 once only", 32'(brkReq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++; totalCnt++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    step(); step();
    testReset();
    rst_n = 1'b1;
    step();
    testReset();
    run = 1'b1; step(); step();
    testPc();
    testRunGate();
    testSeqOrder();
    testSeqZero();
    testSeqRestart();
    testData();
    testReg();
    testExt();
    testOr();
    testHold();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule